// File: doc/BRIEF.md
# ISDN Layer-1 Activation State Controller

This block follows the layer-1 activation of an ISDN terminal. It watches the 4-bit indication code that the line transceiver reports through its C/I receive register. It steps through the terminal states and answers with 4-bit commands in a C/I transmit word. Layer 2 can request activation. A supervision timer, advanced by an external tick, limits how long an activation attempt may take. When the timer runs out, the block withdraws the attempt and reports a deactivation.

Two register layouts are supported, and the `ci_mode` input picks between them. With mode 0 the code sits in bits 5:2 and the change flag in bit 1. With mode 1 the code sits in bits 7:4 and the change flag in bit 3. The same mode input formats the transmit word. `l1_active` is high only in the active state and gates data transfer elsewhere in the chip.

Top module: `l1_activation_ctrl`

## Requirements
- R1: During and after reset the block is in the reset state, `tx_load`, `act_ind` and `deact_ind` are low, `l1_active` is low and the transmit word holds the DI command. `l1_state` reports 0 = reset, 1 = F3 powered-down, 2 = F3 power-up, 3 = F3 pending-deactivation, 4..8 = F4..F8, with F7 the active state.
- R2: An indication is accepted only when its change flag is set. Mode 0 takes the code from `ci_rx[5:2]` and the flag from `ci_rx[1]`. Mode 1 takes the code from `ci_rx[7:4]` and the flag from `ci_rx[3]`. Indication codes are DR=0000, RES=0001, RSY=0100, DR6=0101, EI=0110, PU=0111, AR=1000, AI8=1100 and DC=1111.
- R3: `ci_tx` is `{2'b00, cmd, 2'b11}` in mode 0 and `{cmd, 4'b1110}` in mode 1, with DI=1111 and AR8=1000. `tx_load` pulses for one cycle whenever a command is written, even if the command is the same as before.
- R4: RES or EI moves any state to reset and writes DI. If the state was F7, the block also raises `deact_ind`.
- R5: AI8 in any state other than F7 stops the supervision timer, enters F7, writes AR8 and pulses `act_ind`. `l1_active` is high exactly while the state is F7.
- R6: DC moves reset, F3 pending, F4, F5, F6 and F8 to F3 powered-down. PU moves F3 powered-down to F4. RSY moves F3 powered-down, F3 pending and F4 to F5, and moves F6 to F8.
- R7: AR moves reset, F3 powered-down, F3 pending, F5 and F8 to F6. DR in F5 or F8, and DR6 in F6, move the block to F3 pending and write DI.
- R8: In F7, AR leads to F6, RSY leads to F8 and DR leads to F3 pending with DI written. Each of these exits pulses `deact_ind`.
- R9: `act_req` in F3 powered-down restarts the supervision timer from zero and writes AR8. In any other state it is ignored. `deact_req` never has an effect.
- R10: The timer expires on the TMR_LIMIT-th counted tick after its last restart and is then idle. In the cycle after that tick edge, it writes DI and pulses `deact_ind` if the state is F3 powered-down, F4, F5, F6 or F8, and the state does not change. In other states the expiry is dropped.
- R11: Any state and indication pair that is not listed leaves the state, the transmit word and the pulses unchanged.
- R12: The events of one cycle are ranked: an accepted indication first, then a timer expiry, then an activate request. A lower-ranked event in the same cycle is discarded.
- R13: Outputs change at the clock edge that samples the inputs. The pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ci_mode | input | 1 | C/I register layout select |
| ci_rx | input | 8 | C/I receive register value |
| act_req | input | 1 | Activate request from layer 2 |
| deact_req | input | 1 | Deactivate request from layer 2 (no effect) |
| tmr_tick | input | 1 | Supervision timer tick |
| ci_tx | output | 8 | C/I transmit word |
| tx_load | output | 1 | One-cycle pulse when a command is written |
| act_ind | output | 1 | Activate indication pulse |
| deact_ind | output | 1 | Deactivate indication pulse |
| l1_active | output | 1 | High in the active state |
| l1_state | output | 4 | Current terminal state code |

## Verification
On every cycle, the assertions check four things. The state moves only on an accepted indication. The pulses appear only after an indication or a timer expiry, and `act_ind` and `deact_ind` never appear together. Entering the active state comes with an activate pulse, and leaving it comes with a deactivate pulse. The transmit word changes only with a load pulse or a mode change. The bench's scenarios are needed for the rest: the exact transition table, both register layouts, the tick count at which the timer expires, the restart and stop of the timer, and the ranking of coinciding events.

// File: rtl/l1act_pkg.sv
package l1act_pkg;

  localparam int CI_W    = 8;
  localparam int CODE_W  = 4;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_RESET   = 4'd0,
    ST_F3_PDN  = 4'd1,
    ST_F3_PUP  = 4'd2,
    ST_F3_PEND = 4'd3,
    ST_F4      = 4'd4,
    ST_F5      = 4'd5,
    ST_F6      = 4'd6,
    ST_F7      = 4'd7,
    ST_F8      = 4'd8
  } l1_state_e;

  // indication codes received from the transceiver
  localparam logic [CODE_W-1:0] IND_DEACT   = 4'b0000;
  localparam logic [CODE_W-1:0] IND_RESET   = 4'b0001;
  localparam logic [CODE_W-1:0] IND_TEST    = 4'b0010;
  localparam logic [CODE_W-1:0] IND_SLIP    = 4'b0011;
  localparam logic [CODE_W-1:0] IND_RESYNC  = 4'b0100;
  localparam logic [CODE_W-1:0] IND_DEACT6  = 4'b0101;
  localparam logic [CODE_W-1:0] IND_ERROR   = 4'b0110;
  localparam logic [CODE_W-1:0] IND_PWRUP   = 4'b0111;
  localparam logic [CODE_W-1:0] IND_ACTREQ  = 4'b1000;
  localparam logic [CODE_W-1:0] IND_ACT8    = 4'b1100;
  localparam logic [CODE_W-1:0] IND_DCONF   = 4'b1111;

  // commands sent to the transceiver
  localparam logic [CODE_W-1:0] CMD_TIMING  = 4'b0000;
  localparam logic [CODE_W-1:0] CMD_RESET   = 4'b0001;
  localparam logic [CODE_W-1:0] CMD_ACT8    = 4'b1000;
  localparam logic [CODE_W-1:0] CMD_DEACT   = 4'b1111;

  function automatic logic [CODE_W-1:0] ci_code(input logic mode, input logic [CI_W-1:0] rx);
    return mode ? rx[7:4] : rx[5:2];
  endfunction

  function automatic logic ci_flag(input logic mode, input logic [CI_W-1:0] rx);
    return mode ? rx[3] : rx[1];
  endfunction

  function automatic logic [CI_W-1:0] ci_word(input logic mode, input logic [CODE_W-1:0] cmd);
    return mode ? {cmd, 4'b1110} : {2'b00, cmd, 2'b11};
  endfunction

endpackage

// File: rtl/l1act_ci_decode.sv
module l1act_ci_decode
  import l1act_pkg::*;
(
  input  logic              mode,
  input  logic [CI_W-1:0]   rx,
  output logic              valid,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    valid = ci_flag(mode, rx);
    code  = ci_code(mode, rx);
  end
endmodule

// File: rtl/l1act_ci_encode.sv
module l1act_ci_encode
  import l1act_pkg::*;
(
  input  logic              mode,
  input  logic [CODE_W-1:0] cmd,
  output logic [CI_W-1:0]   word
);
  always_comb word = ci_word(mode, cmd);
endmodule

// File: rtl/l1act_sup_timer.sv
module l1act_sup_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic stop,
  input  logic tick,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      expire <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      run_q  <= 1'b1;
      expire <= 1'b0;
    end else if (stop) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (run_q && tick) begin
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          run_q  <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/l1act_fsm.sv
module l1act_fsm
  import l1act_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ind_valid,
  input  logic [CODE_W-1:0] ind_code,
  input  logic              tmr_expire,
  input  logic              act_req,
  output l1_state_e         state_q,
  output logic [CODE_W-1:0] cmd_q,
  output logic              load_q,
  output logic              ai_q,
  output logic              di_q,
  output logic              tmr_restart,
  output logic              tmr_stop
);
  l1_state_e         nxt;
  logic [CODE_W-1:0] cmd_n;
  logic              load_n, ai_n, di_n;

  function automatic logic expiry_state(input l1_state_e s);
    return (s == ST_F3_PDN) || (s == ST_F4) || (s == ST_F5) ||
           (s == ST_F6) || (s == ST_F8);
  endfunction

  always_comb begin
    nxt         = state_q;
    cmd_n       = cmd_q;
    load_n      = 1'b0;
    ai_n        = 1'b0;
    di_n        = 1'b0;
    tmr_restart = 1'b0;
    tmr_stop    = 1'b0;
    if (ind_valid) begin
      case (ind_code)
        IND_RESET, IND_ERROR: begin
          nxt    = ST_RESET;
          cmd_n  = CMD_DEACT;
          load_n = 1'b1;
          di_n   = (state_q == ST_F7);
        end
        IND_ACT8: begin
          if (state_q != ST_F7) begin
            nxt      = ST_F7;
            cmd_n    = CMD_ACT8;
            load_n   = 1'b1;
            ai_n     = 1'b1;
            tmr_stop = 1'b1;
          end
        end
        IND_DCONF: begin
          if (state_q == ST_RESET || state_q == ST_F3_PEND || state_q == ST_F4 ||
              state_q == ST_F5 || state_q == ST_F6 || state_q == ST_F8)
            nxt = ST_F3_PDN;
        end
        IND_PWRUP: begin
          if (state_q == ST_F3_PDN) nxt = ST_F4;
        end
        IND_RESYNC: begin
          case (state_q)
            ST_F3_PDN, ST_F3_PEND, ST_F4: nxt = ST_F5;
            ST_F6: nxt = ST_F8;
            ST_F7: begin
              nxt  = ST_F8;
              di_n = 1'b1;
            end
            default: ;
          endcase
        end
        IND_ACTREQ: begin
          case (state_q)
            ST_RESET, ST_F3_PDN, ST_F3_PEND, ST_F5, ST_F8: nxt = ST_F6;
            ST_F7: begin
              nxt  = ST_F6;
              di_n = 1'b1;
            end
            default: ;
          endcase
        end
        IND_DEACT: begin
          if (state_q == ST_F5 || state_q == ST_F8 || state_q == ST_F7) begin
            nxt    = ST_F3_PEND;
            cmd_n  = CMD_DEACT;
            load_n = 1'b1;
            di_n   = (state_q == ST_F7);
          end
        end
        IND_DEACT6: begin
          if (state_q == ST_F6) begin
            nxt    = ST_F3_PEND;
            cmd_n  = CMD_DEACT;
            load_n = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (tmr_expire) begin
      if (expiry_state(state_q)) begin
        cmd_n  = CMD_DEACT;
        load_n = 1'b1;
        di_n   = 1'b1;
      end
    end else if (act_req) begin
      if (state_q == ST_F3_PDN) begin
        cmd_n       = CMD_ACT8;
        load_n      = 1'b1;
        tmr_restart = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      cmd_q   <= CMD_DEACT;
      load_q  <= 1'b0;
      ai_q    <= 1'b0;
      di_q    <= 1'b0;
    end else begin
      state_q <= nxt;
      cmd_q   <= cmd_n;
      load_q  <= load_n;
      ai_q    <= ai_n;
      di_q    <= di_n;
    end
  end
endmodule

// File: rtl/l1_activation_ctrl.sv
module l1_activation_ctrl
  import l1act_pkg::*;
#(
  parameter int TMR_LIMIT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ci_mode,
  input  logic [CI_W-1:0]    ci_rx,
  input  logic               act_req,
  input  logic               deact_req,
  input  logic               tmr_tick,
  output logic [CI_W-1:0]    ci_tx,
  output logic               tx_load,
  output logic               act_ind,
  output logic               deact_ind,
  output logic               l1_active,
  output logic [STATE_W-1:0] l1_state
);
  logic              ind_valid;
  logic [CODE_W-1:0] ind_code;
  logic              tmr_expire;
  logic              tmr_restart;
  logic              tmr_stop;
  l1_state_e         state_q;
  logic [CODE_W-1:0] cmd_q;
  logic              unused_deact;

  // layer-2 deactivation has no effect on this block
  assign unused_deact = deact_req;

  l1act_ci_decode u_dec (
    .mode  (ci_mode),
    .rx    (ci_rx),
    .valid (ind_valid),
    .code  (ind_code)
  );

  l1act_sup_timer #(.LIMIT(TMR_LIMIT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .stop    (tmr_stop),
    .tick    (tmr_tick),
    .expire  (tmr_expire)
  );

  l1act_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ind_valid   (ind_valid),
    .ind_code    (ind_code),
    .tmr_expire  (tmr_expire),
    .act_req     (act_req),
    .state_q     (state_q),
    .cmd_q       (cmd_q),
    .load_q      (tx_load),
    .ai_q        (act_ind),
    .di_q        (deact_ind),
    .tmr_restart (tmr_restart),
    .tmr_stop    (tmr_stop)
  );

  l1act_ci_encode u_enc (
    .mode (ci_mode),
    .cmd  (cmd_q),
    .word (ci_tx)
  );

  assign l1_state  = state_q;
  assign l1_active = (state_q == ST_F7);
endmodule

// File: rtl/l1act_chk.sv
module l1act_chk
  import l1act_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ci_mode,
  input logic [CI_W-1:0]    ci_tx,
  input logic               tx_load,
  input logic               act_ind,
  input logic               deact_ind,
  input logic               l1_active,
  input logic [STATE_W-1:0] l1_state,
  input logic               ind_valid,
  input logic               tmr_expire
);
  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_state <= 4'd8);

  // R11
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_valid |=> $stable(l1_state));

  // R12
  no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ind_valid && !tmr_expire) |=> (!act_ind && !deact_ind));

  // R13
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_ind && deact_ind));

  // R5
  enter_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l1_active) |-> (act_ind && tx_load));

  // R8
  leave_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l1_active) |-> deact_ind);

  // R10
  expiry_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expire && !ind_valid &&
     (l1_state == 4'd1 || l1_state == 4'd4 || l1_state == 4'd5 ||
      l1_state == 4'd6 || l1_state == 4'd8))
    |=> (deact_ind && tx_load && $stable(l1_state)));

  // R3
  tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ci_mode) && !tx_load) |-> $stable(ci_tx));
endmodule

bind l1_activation_ctrl l1act_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ci_mode    (ci_mode),
  .ci_tx      (ci_tx),
  .tx_load    (tx_load),
  .act_ind    (act_ind),
  .deact_ind  (deact_ind),
  .l1_active  (l1_active),
  .l1_state   (l1_state),
  .ind_valid  (ind_valid),
  .tmr_expire (tmr_expire)
);

// File: tb/tb_l1_activation_ctrl.sv
module tb_l1_activation_ctrl;
  localparam int LIM = 8;
  localparam int NV  = 38;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ci_mode = 1'b0;
  logic [7:0] ci_rx = 8'h00;
  logic       act_req = 1'b0;
  logic       deact_req = 1'b0;
  logic       tmr_tick = 1'b0;
  logic [7:0] ci_tx;
  logic       tx_load, act_ind, deact_ind, l1_active;
  logic [3:0] l1_state;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  l1_activation_ctrl #(.TMR_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .ci_mode(ci_mode), .ci_rx(ci_rx),
    .act_req(act_req), .deact_req(deact_req), .tmr_tick(tmr_tick),
    .ci_tx(ci_tx), .tx_load(tx_load), .act_ind(act_ind),
    .deact_ind(deact_ind), .l1_active(l1_active), .l1_state(l1_state)
  );

  // vector: mode, rx, {act,deact}, exp state, exp load, exp tx, exp act ind, exp deact ind
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h3E, 2'b00, 4'd1, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h1E, 2'b00, 4'd4, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h22, 2'b00, 4'd4, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h02, 2'b00, 4'd4, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h12, 2'b00, 4'd5, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h22, 2'b00, 4'd6, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h12, 2'b00, 4'd8, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h02, 2'b00, 4'd3, 1'b1, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h3E, 2'b00, 4'd1, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h00, 2'b10, 4'd1, 1'b1, 8'h23, 1'b0, 1'b0},
    {1'b0, 8'h32, 2'b00, 4'd7, 1'b1, 8'h23, 1'b1, 1'b0},
    {1'b0, 8'h32, 2'b00, 4'd7, 1'b0, 8'h23, 1'b0, 1'b0},
    {1'b0, 8'h3E, 2'b00, 4'd7, 1'b0, 8'h23, 1'b0, 1'b0},
    {1'b0, 8'h22, 2'b00, 4'd6, 1'b0, 8'h23, 1'b0, 1'b1},
    {1'b0, 8'h16, 2'b00, 4'd3, 1'b1, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h12, 2'b00, 4'd5, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h32, 2'b00, 4'd7, 1'b1, 8'h23, 1'b1, 1'b0},
    {1'b0, 8'h12, 2'b00, 4'd8, 1'b0, 8'h23, 1'b0, 1'b1},
    {1'b0, 8'h32, 2'b00, 4'd7, 1'b1, 8'h23, 1'b1, 1'b0},
    {1'b0, 8'h02, 2'b00, 4'd3, 1'b1, 8'h3F, 1'b0, 1'b1},
    {1'b0, 8'h30, 2'b00, 4'd3, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h22, 2'b00, 4'd6, 1'b0, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h1A, 2'b00, 4'd0, 1'b1, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h32, 2'b00, 4'd7, 1'b1, 8'h23, 1'b1, 1'b0},
    {1'b0, 8'h06, 2'b00, 4'd0, 1'b1, 8'h3F, 1'b0, 1'b1},
    {1'b1, 8'hF8, 2'b00, 4'd1, 1'b0, 8'hFE, 1'b0, 1'b0},
    {1'b1, 8'h00, 2'b10, 4'd1, 1'b1, 8'h8E, 1'b0, 1'b0},
    {1'b1, 8'hC8, 2'b00, 4'd7, 1'b1, 8'h8E, 1'b1, 1'b0},
    {1'b1, 8'h32, 2'b00, 4'd7, 1'b0, 8'h8E, 1'b0, 1'b0},
    {1'b0, 8'h12, 2'b00, 4'd8, 1'b0, 8'h23, 1'b0, 1'b1},
    {1'b0, 8'h00, 2'b01, 4'd8, 1'b0, 8'h23, 1'b0, 1'b0},
    {1'b0, 8'h12, 2'b00, 4'd8, 1'b0, 8'h23, 1'b0, 1'b0},
    {1'b0, 8'h06, 2'b00, 4'd0, 1'b1, 8'h3F, 1'b0, 1'b0},
    {1'b0, 8'h1A, 2'b00, 4'd0, 1'b1, 8'h3F, 1'b0, 1'b0},
    {1'b1, 8'h06, 2'b00, 4'd0, 1'b0, 8'hFE, 1'b0, 1'b0},
    {1'b1, 8'h88, 2'b00, 4'd6, 1'b0, 8'hFE, 1'b0, 1'b0},
    {1'b1, 8'h08, 2'b00, 4'd6, 1'b0, 8'hFE, 1'b0, 1'b0},
    {1'b1, 8'h58, 2'b00, 4'd3, 1'b1, 8'hFE, 1'b0, 1'b0}
  };

  function automatic logic [7:0] m0(input logic [3:0] code);
    return {2'b00, code, 2'b10};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic m, input logic [7:0] rx, input logic a,
                     input logic d, input logic t);
    @(negedge clk);
    ci_mode = m; ci_rx = rx; act_req = a; deact_req = d; tmr_tick = t;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic t);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, t);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ci_mode = 1'b0; ci_rx = 8'h00;
    act_req = 1'b0; deact_req = 1'b0; tmr_tick = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1 state", 32'(l1_state), 32'd0);
    check("R1 tx", 32'(ci_tx), 32'h3F);
    check("R1 pulses", {29'd0, tx_load, act_ind, deact_ind}, 32'd0);
    check("R1 active", 32'(l1_active), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R11 R13
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      cyc(v[25], v[24:17], v[16], v[15], 1'b0);
      check($sformatf("table %0d state R6 R7 R2", i), 32'(l1_state), 32'(v[14:11]));
      check($sformatf("table %0d load R3 R11", i), 32'(tx_load), 32'(v[10]));
      check($sformatf("table %0d tx R3", i), 32'(ci_tx), 32'(v[9:2]));
      check($sformatf("table %0d act R5", i), 32'(act_ind), 32'(v[1]));
      check($sformatf("table %0d deact R4 R8", i), 32'(deact_ind), 32'(v[0]));
      check($sformatf("table %0d active R5", i), 32'(l1_active), 32'(v[14:11] == 4'd7));
    end

    // R10: expiry after LIM ticks, one cycle later, state kept, one-shot
    do_reset();
    cyc(1'b0, m0(4'hF), 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R9 act load", 32'(tx_load), 32'd1);
    for (int k = 0; k < LIM; k++) begin
      idle(1'b1);
      check("R10 no early deact", 32'(deact_ind), 32'd0);
    end
    idle(1'b0);
    check("R10 deact", 32'(deact_ind), 32'd1);
    check("R10 load", 32'(tx_load), 32'd1);
    check("R10 tx DI", 32'(ci_tx), 32'h3F);
    check("R10 state kept", 32'(l1_state), 32'd1);
    for (int k = 0; k < 2 * LIM; k++) begin
      idle(1'b1);
      if (deact_ind !== 1'b0) check("R10 one-shot", 32'(deact_ind), 32'd0);
    end
    check("R10 one-shot end", 32'(deact_ind), 32'd0);

    // R9 restart from zero
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < LIM - 1; k++) idle(1'b1);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < LIM - 1; k++) begin
      idle(1'b1);
      if (deact_ind !== 1'b0) check("R9 restart", 32'(deact_ind), 32'd0);
    end
    idle(1'b1);
    idle(1'b0);
    check("R9 restart expiry", 32'(deact_ind), 32'd1);

    // R5 timer stopped by AI8
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) idle(1'b1);
    cyc(1'b0, m0(4'hC), 1'b0, 1'b0, 1'b0);
    check("R5 enter F7", 32'(l1_state), 32'd7);
    cyc(1'b0, m0(4'h4), 1'b0, 1'b0, 1'b0);
    check("R8 F7 to F8", 32'(l1_state), 32'd8);
    for (int k = 0; k < 2 * LIM; k++) begin
      idle(1'b1);
      if (deact_ind !== 1'b0) check("R5 timer stopped", 32'(deact_ind), 32'd0);
    end
    check("R5 timer stopped end", 32'(deact_ind), 32'd0);

    // R10 expiry in F4
    do_reset();
    cyc(1'b0, m0(4'hF), 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, m0(4'h7), 1'b0, 1'b0, 1'b0);
    check("R6 PU to F4", 32'(l1_state), 32'd4);
    for (int k = 0; k < LIM; k++) idle(1'b1);
    idle(1'b0);
    check("R10 F4 deact", 32'(deact_ind), 32'd1);
    check("R10 F4 state", 32'(l1_state), 32'd4);

    // R10 expiry dropped in reset
    do_reset();
    cyc(1'b0, m0(4'hF), 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, m0(4'h1), 1'b0, 1'b0, 1'b0);
    check("R4 RES to reset", 32'(l1_state), 32'd0);
    for (int k = 0; k < LIM; k++) idle(1'b1);
    idle(1'b0);
    check("R10 dropped deact", 32'(deact_ind), 32'd0);
    check("R10 dropped load", 32'(tx_load), 32'd0);

    // R12 indication beats expiry
    do_reset();
    cyc(1'b0, m0(4'hF), 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < LIM; k++) idle(1'b1);
    cyc(1'b0, m0(4'h7), 1'b0, 1'b0, 1'b0);
    check("R12 ind wins state", 32'(l1_state), 32'd4);
    check("R12 expiry discarded", 32'(deact_ind), 32'd0);
    idle(1'b0);
    check("R12 expiry gone", 32'(deact_ind), 32'd0);

    // R12 indication beats request; R9 request outside F3 powered-down
    do_reset();
    cyc(1'b0, m0(4'hF), 1'b0, 1'b0, 1'b0);
    cyc(1'b0, m0(4'h7), 1'b1, 1'b0, 1'b0);
    check("R12 req discarded state", 32'(l1_state), 32'd4);
    check("R12 req discarded load", 32'(tx_load), 32'd0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R9 req ignored in F4", 32'(tx_load), 32'd0);
    check("R9 tx kept", 32'(ci_tx), 32'h3F);

    finish_run();
  end
endmodule